// File: doc/BRIEF.md
# Serial Receiver with Prioritised Interrupt Identification

This block turns an asynchronous serial line into bytes for a host. A 16-bit baud divisor, loaded as a high byte and then a low byte, sets a tick at sixteen times the bit rate. A shift engine locks onto a start bit, samples every bit at its midpoint, and checks parity and the stop bit. It also recognises a line held low for a whole frame. Each finished character goes into a 16-entry FIFO together with its error tags. Bytes leave the FIFO through a valid/ready stream port.

Sticky line-status indicators report overrun, parity error, framing error and break. A summary indicator stays set while any errored entry remains queued. A priority encoder combines three causes into a 3-bit identification code and an active-low pending flag. The causes are line status, data at or above a selectable trigger level, and a character timeout. The host pulses `lsr_rd` to acknowledge line status.

Back-pressure: `rd_valid` is high whenever the FIFO holds a byte, and `rd_data` shows the oldest byte. An entry is removed on a clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` has no effect while `rd_valid` is low. The receiver never waits for the host. A character that completes while all 16 entries are occupied is dropped and flagged as overrun.

Top module: `uart_rx_irq`

## Requirements
- R1: The divisor resets to 0. While it is 0, nothing is received. Writing the high byte stops the baud counter until the low byte is written, and the counter restarts from zero at that write. One tick is produced every divisor clocks.
- R2: `char_len` codes 00/01/10/11 select 5/6/7/8 data bits. Bits arrive LSB first, and the byte is zero-extended to 8 bits in `rd_data`.
- R3: When `par_en` is 1, a parity bit follows the data. `par_even`=1 selects even parity and 0 selects odd. When `par_stick`=1 the expected parity bit is fixed: 0 if `par_even`=1, and 1 if `par_even`=0. A mismatch sets `st_parity`.
- R4: A falling edge starts a start bit, which is re-sampled on the 8th tick. If the line is high again at that tick, the start is dropped and no character results.
- R5: The FIFO holds 16 entries in arrival order. Its output is the valid/ready port described above.
- R6: If a character completes while the FIFO holds 16 entries, `st_overrun` sets, the character is discarded and the queued entries stay unchanged.
- R7: A stop bit sampled low sets `st_framing`. If the whole frame is low (data 0, parity bit 0 or absent, stop low), one 0x00 entry is queued and `st_break` sets. No further character is accepted until the line returns high.
- R8: `st_overrun`, `st_parity`, `st_framing` and `st_break` remain set until an `lsr_rd` pulse clears them. `st_err_any` is 1 while any queued entry carries a parity, framing or break tag.
- R9: `trig_sel` codes 00/01/10/11 set the trigger level to 1/4/8/14 entries. When the FIFO holds at least that many entries, the data-available cause is active.
- R10: The timeout cause activates when the FIFO is non-empty and no push, pop or `lsr_rd` has occurred for 4 character times. One character time is 16 ticks per frame bit. The cause clears on `lsr_rd`, a push, a pop or `fifo_clr`.
- R11: `irq_id` is 011 for line status, else 010 for data available, else 110 for timeout, else 000. `irq_idle` is 0 exactly when a cause is active.
- R12: `fifo_clr` empties the FIFO and its error tags without disturbing the character currently being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| div_wr_hi | input | 1 | Load `div_byte` into divisor bits 15:8 |
| div_wr_lo | input | 1 | Load `div_byte` into divisor bits 7:0 and start the counter |
| div_byte | input | 8 | Divisor byte |
| char_len | input | 2 | Data bits per character code |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even (1) or odd (0) parity |
| par_stick | input | 1 | Fixed parity bit |
| trig_sel | input | 2 | Trigger level code |
| fifo_clr | input | 1 | Empty the FIFO |
| lsr_rd | input | 1 | Line-status read strobe |
| rd_valid | output | 1 | FIFO non-empty (data ready) |
| rd_ready | input | 1 | Host accepts the head byte |
| rd_data | output | 8 | Head byte |
| st_overrun | output | 1 | Overrun indicator |
| st_parity | output | 1 | Parity error indicator |
| st_framing | output | 1 | Framing error indicator |
| st_break | output | 1 | Break indicator |
| st_err_any | output | 1 | Errored entry present in the FIFO |
| irq_id | output | 3 | Interrupt identification code |
| irq_idle | output | 1 | 1 when no interrupt is pending |

## Verification
The assertions assume three things about the inputs:
- The divisor and line settings are changed only while the line is idle.
- `lsr_rd` and `rd_ready` are single-cycle or level strobes aligned to the clock.
- The serial bit period matches sixteen ticks.

The stimulus follows these rules. It changes configuration only between frames. It drives every bit for exactly sixteen divisor periods. It pulses `fifo_clr` only while a character is in flight, which is where R12 needs it. The glitch and break cases deliberately break the frame timing, but they stay on whole clock periods.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_char_t;

  localparam logic [2:0] IID_LINE = 3'b011;
  localparam logic [2:0] IID_DATA = 3'b010;
  localparam logic [2:0] IID_TMO  = 3'b110;
  localparam logic [2:0] IID_NONE = 3'b000;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // start + data(5..8) + parity + stop
  function automatic logic [3:0] frame_bits(input logic [1:0] len, input logic pen);
    return 4'd7 + {2'b00, len} + {3'b000, pen};
  endfunction
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [7:0] wr_byte,
  output logic       tick
);
  logic [DIV_W-1:0] div_q, cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (wr_hi) begin
      div_q[DIV_W-1:8] <= wr_byte[DIV_W-9:0];
      run_q            <= 1'b0;
      cnt_q            <= '0;
    end else if (wr_lo) begin
      div_q[7:0] <= wr_byte;
      run_q      <= 1'b1;
      cnt_q      <= '0;
    end else if (run_q && div_q != '0) begin
      cnt_q <= (cnt_q == div_q - 1'b1) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = run_q && (div_q != '0) && (cnt_q == div_q - 1'b1);

  assert_hold_after_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hi) |-> !tick);
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       done,
  output rx_char_t   chr
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        st;
  logic       rx_m, rx_s, pbit;
  logic [3:0] phase;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic [2:0] last_bit;
  logic       mid, exp_par, brk_w;

  assign last_bit = 3'd4 + {1'b0, char_len};
  assign mid      = tick && (phase == 4'd15);
  assign exp_par  = par_stick ? ~par_even : (par_even ? ^shreg : ~^shreg);
  assign brk_w    = !rx_s && (shreg == 8'h00) && !(par_en && pbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1;
      st <= S_IDLE; phase <= '0; bitn <= '0; shreg <= '0; pbit <= 1'b0;
      done <= 1'b0; chr <= '0;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
      done <= 1'b0;
      case (st)
        S_IDLE: if (tick && !rx_s) begin st <= S_START; phase <= '0; end
        S_START: if (tick) begin
          if (phase == 4'd7) begin
            if (!rx_s) begin st <= S_DATA; phase <= '0; bitn <= '0; shreg <= '0; end
            else st <= S_IDLE;
          end else phase <= phase + 4'd1;
        end
        S_DATA: if (tick) begin
          phase <= phase + 4'd1;
          if (phase == 4'd15) begin
            shreg[bitn] <= rx_s;
            if (bitn == last_bit) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 3'd1;
          end
        end
        S_PAR: if (tick) begin
          phase <= phase + 4'd1;
          if (mid) begin pbit <= rx_s; st <= S_STOP; end
        end
        S_STOP: if (tick) begin
          phase <= phase + 4'd1;
          if (mid) begin
            done     <= 1'b1;
            chr.brk  <= brk_w;
            chr.frm  <= !rx_s;
            chr.par  <= par_en && !brk_w && (pbit != exp_par);
            chr.data <= brk_w ? 8'h00 : shreg;
            st       <= brk_w ? S_HOLD : S_IDLE;
          end
        end
        default: if (rx_s) st <= S_IDLE;
      endcase
    end
  end

  assert_done_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick));
  assert_break_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chr.brk) |-> (chr.data == 8'h00 && chr.frm));
  assert_start_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_START) |-> $past(!rx_s));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) if (do_push && !clr) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       div_wr_hi,
  input  logic       div_wr_lo,
  input  logic [7:0] div_byte,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic [1:0] trig_sel,
  input  logic       fifo_clr,
  input  logic       lsr_rd,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       st_overrun,
  output logic       st_parity,
  output logic       st_framing,
  output logic       st_break,
  output logic       st_err_any,
  output logic [2:0] irq_id,
  output logic       irq_idle
);
  logic          tick, done, full, empty, push, pop;
  rx_char_t      chr, head;
  logic [CW-1:0] count, err_cnt;
  logic [TW-1:0] tmo_cnt, tmo_lim;
  logic          line_c, data_c, tmo_c, in_err, out_err;

  uart_rx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .wr_hi(div_wr_hi), .wr_lo(div_wr_lo),
    .wr_byte(div_byte), .tick(tick));

  uart_rx_shift i_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_line), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .done(done), .chr(chr));

  uart_rx_fifo #(.W($bits(rx_char_t)), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .wdata(chr),
    .pop(pop), .rdata(head), .count(count), .full(full), .empty(empty));

  assign push     = done && !full;
  assign rd_valid = !empty;
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = head.data;
  assign in_err   = chr.par | chr.frm | chr.brk;
  assign out_err  = head.par | head.frm | head.brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_overrun <= 1'b0; st_parity <= 1'b0; st_framing <= 1'b0; st_break <= 1'b0;
      err_cnt <= '0;
    end else begin
      st_overrun <= (done && full)      | (st_overrun && !lsr_rd);
      st_parity  <= (push && chr.par)   | (st_parity  && !lsr_rd);
      st_framing <= (push && chr.frm)   | (st_framing && !lsr_rd);
      st_break   <= (push && chr.brk)   | (st_break   && !lsr_rd);
      if (fifo_clr) err_cnt <= '0;
      else err_cnt <= err_cnt + CW'(push && in_err) - CW'(pop && out_err);
    end
  end
  assign st_err_any = (err_cnt != '0);

  assign tmo_lim = {frame_bits(char_len, par_en), 6'b0};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_cnt <= '0;
    else if (fifo_clr || push || pop || lsr_rd || empty) tmo_cnt <= '0;
    else if (tick && tmo_cnt < tmo_lim) tmo_cnt <= tmo_cnt + 1'b1;
  end

  assign line_c   = st_overrun | st_parity | st_framing | st_break;
  assign data_c   = (count >= CW'(trig_level(trig_sel)));
  assign tmo_c    = !empty && (tmo_cnt >= tmo_lim);
  assign irq_idle = !(line_c | data_c | tmo_c);
  always_comb begin
    if (line_c)      irq_id = IID_LINE;
    else if (data_c) irq_id = IID_DATA;
    else if (tmo_c)  irq_id = IID_TMO;
    else             irq_id = IID_NONE;
  end

  assert_line_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overrun || st_parity || st_framing || st_break) |-> irq_id == IID_LINE);
  assert_idle_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_idle == (irq_id == IID_NONE));
  assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !pop && !fifo_clr) |=> full);
  assert_err_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_err_any |-> rd_valid);
endmodule

// File: tb/test_uart_rx_irq.sv
module test_uart_rx_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_line = 1'b1, div_wr_hi = 1'b0, div_wr_lo = 1'b0;
  logic [7:0] div_byte = '0;
  logic [1:0] char_len = 2'b11, trig_sel = 2'b00;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic fifo_clr = 1'b0, lsr_rd = 1'b0, rd_ready = 1'b0;
  logic rd_valid, st_overrun, st_parity, st_framing, st_break, st_err_any, irq_idle;
  logic [7:0] rd_data;
  logic [2:0] irq_id;
  int checks = 0, failures = 0;
  localparam int BITCLK = 32;   // divisor 2 -> 16 ticks x 2 clocks

  // {len[1:0], pen, even, stick, flip, 2'b00, data[7:0]}
  localparam logic [15:0] VEC [8] = '{16'hC0A5, 16'h0013, 16'hF03C, 16'hA055,
                                      16'hF881, 16'h682A, 16'hF4C3, 16'h6C15};

  always #2 clk = ~clk;

  uart_rx_irq i_uart_rx_irq (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .div_wr_hi(div_wr_hi),
    .div_wr_lo(div_wr_lo), .div_byte(div_byte), .char_len(char_len), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .trig_sel(trig_sel), .fifo_clr(fifo_clr),
    .lsr_rd(lsr_rd), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .st_overrun(st_overrun), .st_parity(st_parity), .st_framing(st_framing),
    .st_break(st_break), .st_err_any(st_err_any), .irq_id(irq_id), .irq_idle(irq_idle));

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_hi(input logic [7:0] b);
    div_byte = b; div_wr_hi = 1'b1; clks(1); div_wr_hi = 1'b0;
  endtask
  task automatic pulse_lo(input logic [7:0] b);
    div_byte = b; div_wr_lo = 1'b1; clks(1); div_wr_lo = 1'b0;
  endtask
  task automatic read_lsr();
    lsr_rd = 1'b1; clks(1); lsr_rd = 1'b0; clks(1);
  endtask
  task automatic pop_one();
    rd_ready = 1'b1; clks(1); rd_ready = 1'b0; clks(1);
  endtask

  task automatic send(input logic [7:0] d, input logic pbit, input logic stopv);
    int nb;
    nb = 5 + int'(char_len);
    rx_line = 1'b0; clks(BITCLK);
    for (int i = 0; i < nb; i++) begin rx_line = d[i]; clks(BITCLK); end
    if (par_en) begin rx_line = pbit; clks(BITCLK); end
    rx_line = stopv; clks(BITCLK);
    rx_line = 1'b1; clks(4);
  endtask

  function automatic logic good_par(input logic [7:0] d);
    if (par_stick) return ~par_even;
    return par_even ? ^d : ~^d;
  endfunction

  initial begin
    clks(150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clks(3); rst_n = 1'b1; clks(2);
    // reset state
    check("R5 reset rd_valid", rd_valid, 0);
    check("R11 reset irq_idle", irq_idle, 1);
    check("R11 reset irq_id", irq_id, 0);
    check("R8 reset flags", {st_overrun, st_parity, st_framing, st_break, st_err_any}, 0);

    // R1: zero divisor receives nothing
    send(8'h5A, 1'b0, 1'b1);
    check("R1 zero divisor ignores line", rd_valid, 0);
    pulse_hi(8'h00); pulse_lo(8'h02);
    pulse_hi(8'h00);
    send(8'h5A, 1'b0, 1'b1);
    check("R1 held after high byte", rd_valid, 0);
    pulse_lo(8'h02);

    // vector table: R2 R3 R5
    for (int v = 0; v < 8; v++) begin
      logic [7:0] d, m;
      char_len  = VEC[v][15:14];
      par_en    = VEC[v][13];
      par_even  = VEC[v][12];
      par_stick = VEC[v][11];
      m = 8'hFF >> (3 - int'(char_len));
      d = VEC[v][7:0] & m;
      send(d, good_par(d) ^ VEC[v][10], 1'b1);
      check("R5 char available", rd_valid, 1);
      check("R2 data bits", rd_data, d);
      check("R3 parity flag", st_parity, int'(VEC[v][10]));
      pop_one(); read_lsr();
      check("R5 drained", rd_valid, 0);
    end
    char_len = 2'b11; par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0;

    // R4 glitch
    rx_line = 1'b0; clks(8); rx_line = 1'b1; clks(400);
    check("R4 glitch rejected", rd_valid, 0);

    // R7 framing, R11 priority, R8 clear rules, R9 level 1
    send(8'h33, 1'b0, 1'b0);
    check("R7 framing flag", st_framing, 1);
    check("R11 line status first", irq_id, 3'b011);
    check("R11 pending flag low", irq_idle, 0);
    check("R8 err summary set", st_err_any, 1);
    read_lsr();
    check("R8 framing cleared", st_framing, 0);
    check("R9 data available at 1", irq_id, 3'b010);
    check("R8 summary still set", st_err_any, 1);
    pop_one();
    check("R8 summary cleared on pop", st_err_any, 0);
    check("R11 no cause idle", irq_idle, 1);

    // R7 break
    rx_line = 1'b0; clks(11 * BITCLK); rx_line = 1'b1; clks(2 * BITCLK);
    check("R7 break char queued", rd_valid, 1);
    check("R7 break data zero", rd_data, 0);
    check("R7 break flag", st_break, 1);
    pop_one();
    check("R7 single break entry", rd_valid, 0);
    read_lsr();
    check("R8 break cleared", st_break, 0);

    // R9 trigger 4
    trig_sel = 2'b01;
    send(8'h11, 1'b0, 1'b1); send(8'h22, 1'b0, 1'b1); send(8'h33, 1'b0, 1'b1);
    check("R9 below level 4", irq_id, 3'b000);
    send(8'h44, 1'b0, 1'b1);
    check("R9 level 4 reached", irq_id, 3'b010);
    pop_one();
    check("R9 below level after pop", irq_id, 3'b000);

    // R10 timeout
    clks(1400);
    check("R10 timeout id", irq_id, 3'b110);
    read_lsr();
    check("R10 timeout cleared by lsr", irq_idle, 1);
    check("R5 order head", rd_data, 8'h22);
    pop_one(); pop_one(); pop_one();
    check("R5 empty after drain", rd_valid, 0);

    // R6 overrun with trigger 14
    trig_sel = 2'b11;
    for (int i = 0; i < 16; i++) send(8'h40 + 8'(i), 1'b0, 1'b1);
    check("R9 level 14 reached", irq_id, 3'b010);
    send(8'h99, 1'b0, 1'b1);
    check("R6 overrun flag", st_overrun, 1);
    check("R11 overrun is line status", irq_id, 3'b011);
    read_lsr();
    check("R8 overrun cleared", st_overrun, 0);
    for (int i = 0; i < 16; i++) begin
      check("R6 contents intact", rd_data, 8'h40 + i);
      pop_one();
    end
    check("R6 overrun char dropped", rd_valid, 0);

    // R12 clear during shifting
    trig_sel = 2'b00;
    send(8'h10, 1'b0, 1'b1);
    check("R12 one entry before clear", rd_valid, 1);
    fork
      send(8'h6B, 1'b0, 1'b1);
      begin
        clks(100); fifo_clr = 1'b1; clks(1); fifo_clr = 1'b0;
        check("R12 cleared", rd_valid, 0);
      end
    join
    check("R12 in-flight char kept", rd_data, 8'h6B);
    pop_one();
    check("R12 only new char", rd_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule